// File: doc/BRIEF.md
# Low-power mode controller

This block holds a two-bit power-control register and steps the core between three operating states: running, idle and power-down. Software in the running state writes the register to request a low-power state. In idle, the CPU clock stops while the oscillator and the peripheral clock (interrupt, serial and timer logic) keep running. In power-down, the oscillator and both clock enables are off.

The two low-power states leave by different routes. Idle returns to running on a hardware interrupt or on a hardware reset. Power-down returns only on a hardware reset, and that reset reinitialises the control registers but never asks for RAM to be cleared. The clock-enable outputs drive gating cells and an oscillator that sit outside this block.

Top module: `lpm_ctl`

## Requirements
- R1: After a reset the state is running (mode code 0), the control register reads 0, and the CPU clock, peripheral clock and oscillator enables are all 1. The reinitialise strobe is 1 in every cycle that follows a clock edge at which reset was high.
- R2: In running, a write with data bit 0 (idle request) set and bit 1 clear moves the state to idle (mode code 1) at that edge, and register bit 0 reads 1.
- R3: In running, a write with data bit 1 (power-down request) set moves the state to power-down (mode code 2) at that edge, and register bit 1 reads 1.
- R4: When a write sets both bits, power-down wins and register bit 0 is stored as 0.
- R5: In idle, the CPU clock enable is 0 and the peripheral clock and oscillator enables are 1.
- R6: In power-down, the oscillator, peripheral clock and CPU clock enables are all 0.
- R7: An interrupt in idle returns the state to running at the next edge, clears register bit 0 and restores the CPU clock enable.
- R8: An interrupt in power-down has no effect; the state and the register are unchanged.
- R9: Writes in idle or power-down are ignored. In running, an interrupt changes nothing, and a write with neither bit set leaves the state at running.
- R10: A hardware reset returns the block to running from any state, and the RAM-clear output is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| wr_en | input | 1 | Write strobe for the power-control register |
| wr_data | input | 2 | Write data: bit 0 idle request, bit 1 power-down request |
| irq | input | 1 | Hardware interrupt request |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Enable for the interrupt, serial and timer clock |
| osc_en | output | 1 | Oscillator enable |
| reinit_stb | output | 1 | Register reinitialise strobe |
| ram_clear | output | 1 | RAM clear request, held at 0 |
| mode | output | 2 | Current state: 0 running, 1 idle, 2 power-down |
| ctl_bits | output | 2 | Power-control register contents |

## Verification
A write or an interrupt takes effect at the clock edge where it is sampled. The mode, the register and the three enables all change at that same edge, because the enables are decoded from the state register without a further register. The reinitialise strobe is a single register behind reset, so it reads high in the cycle after each reset edge. The bench drives inputs on the falling edge, updates its own model at the rising edge, and compares every output at the next falling edge. Each result is therefore checked in the cycle it first appears.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    M_RUN  = 2'd0,
    M_IDLE = 2'd1,
    M_PDN  = 2'd2
  } mode_t;

  // Next state from the current state and the events of one cycle.
  function automatic mode_t next_mode(mode_t cur, logic go_pdn, logic go_idle,
                                      logic wake);
    mode_t n;
    n = cur;
    case (cur)
      M_RUN:   if (go_pdn) n = M_PDN; else if (go_idle) n = M_IDLE;
      M_IDLE:  if (wake) n = M_RUN;
      default: n = M_PDN;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/lpm_ctl_reg.sv
module lpm_ctl_reg #(
  parameter int CTL_W   = 2,
  parameter int IDLE_BIT = 0,
  parameter int PDN_BIT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             accept,
  input  logic             clr_idle,
  output logic             go_pdn,
  output logic             go_idle,
  output logic [CTL_W-1:0] ctl_q
);
  logic wr_ok;
  assign wr_ok   = wr_en && accept;
  assign go_pdn  = wr_ok && wr_data[PDN_BIT];
  assign go_idle = wr_ok && wr_data[IDLE_BIT] && !wr_data[PDN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_ok) begin
      ctl_q           <= '0;
      ctl_q[PDN_BIT]  <= go_pdn;
      ctl_q[IDLE_BIT] <= go_idle;
    end else if (clr_idle) begin
      ctl_q[IDLE_BIT] <= 1'b0;
    end
  end

  // R4: power-down takes precedence when both bits are written
  a_r4_pdn_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_data[PDN_BIT] && wr_data[IDLE_BIT]) |=> (ctl_q[PDN_BIT] && !ctl_q[IDLE_BIT]));
  // R9: the register holds when writes are refused
  a_r9_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept && !clr_idle) |=> $stable(ctl_q));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go_pdn,
  input  logic  go_idle,
  input  logic  irq,
  output mode_t st_q,
  output logic  accept,
  output logic  wake_evt,
  output logic  reinit_q
);
  assign accept   = (st_q == M_RUN);
  assign wake_evt = (st_q == M_IDLE) && irq;

  always_ff @(posedge clk) begin
    if (rst) st_q <= M_RUN;
    else     st_q <= next_mode(st_q, go_pdn, go_idle, wake_evt);
    reinit_q <= rst;
  end

  // R7: an interrupt wakes the core from idle
  a_r7_irq_wake: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> (st_q == M_RUN));
  // R8: power-down is left only through reset
  a_r8_pdn_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_q == M_PDN) |=> (st_q == M_PDN));
  // R2: an idle request from running enters idle
  a_r2_enter_idle: assert property (@(posedge clk) disable iff (rst)
    (go_idle && !go_pdn) |=> (st_q == M_IDLE));
  // R3: a power-down request enters power-down
  a_r3_enter_pdn: assert property (@(posedge clk) disable iff (rst)
    go_pdn |=> (st_q == M_PDN));
  // R10: reset always restores running
  a_r10_reset_run: assert property (@(posedge clk)
    rst |=> (st_q == M_RUN));
endmodule

// File: rtl/lpm_ctl.sv
module lpm_ctl
  import lpm_pkg::*;
#(
  parameter int CTL_W    = 2,
  parameter int IDLE_BIT = 0,
  parameter int PDN_BIT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             irq,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             reinit_stb,
  output logic             ram_clear,
  output logic [MODE_W-1:0] mode,
  output logic [CTL_W-1:0] ctl_bits
);
  mode_t st;
  logic  accept, wake_evt, go_pdn, go_idle;

  lpm_ctl_reg #(.CTL_W(CTL_W), .IDLE_BIT(IDLE_BIT), .PDN_BIT(PDN_BIT)) reg_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .accept(accept), .clr_idle(wake_evt),
    .go_pdn(go_pdn), .go_idle(go_idle), .ctl_q(ctl_bits)
  );

  lpm_seq seq_i (
    .clk(clk), .rst(rst), .go_pdn(go_pdn), .go_idle(go_idle), .irq(irq),
    .st_q(st), .accept(accept), .wake_evt(wake_evt), .reinit_q(reinit_stb)
  );

  assign cpu_clk_en = (st == M_RUN);
  assign per_clk_en = (st != M_PDN);
  assign osc_en     = (st != M_PDN);
  assign ram_clear  = 1'b0;
  assign mode       = st;

  // R5: idle stops only the CPU clock
  a_r5_idle_clocks: assert property (@(posedge clk) disable iff (rst)
    (mode == M_IDLE) |-> (!cpu_clk_en && per_clk_en && osc_en));
  // R6: power-down stops everything
  a_r6_pdn_clocks: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PDN) |-> (!cpu_clk_en && !per_clk_en && !osc_en && ctl_bits[PDN_BIT]));
endmodule

// File: tb/lpm_ctl_tb.sv
module lpm_ctl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_data = '0;
  logic irq = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, reinit_stb, ram_clear;
  logic [1:0] mode, ctl_bits;
  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [1:0] e_mode = 2'd0, e_ctl = 2'd0;
  logic e_reinit = 1'b0;

  always #10 clk = ~clk;

  lpm_ctl dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .irq(irq),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .reinit_stb(reinit_stb), .ram_clear(ram_clear), .mode(mode), .ctl_bits(ctl_bits));

  // Model: advance expected state at each rising edge from the sampled inputs.
  function automatic logic [3:0] model(logic [1:0] m, logic [1:0] c, logic r,
                                       logic w, logic [1:0] d, logic i);
    if (r) return 4'b0000;
    if (m == 2'd0 && w) begin
      if (d[1]) return {2'd2, 2'b10};
      if (d[0]) return {2'd1, 2'b01};
      return {2'd0, 2'b00};
    end
    if (m == 2'd1 && i) return {2'd0, c & 2'b10};
    return {m, c};
  endfunction

  always @(posedge clk) begin
    logic [3:0] nx;
    nx = model(e_mode, e_ctl, rst, wr_en, wr_data, irq);
    e_mode <= nx[3:2];
    e_ctl  <= nx[1:0];
    e_reinit <= rst;
    cycles <= cycles + 1;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " mode"}, {6'd0, mode}, {6'd0, e_mode});
    chk({req, " ctl"}, {6'd0, ctl_bits}, {6'd0, e_ctl});
    chk({req, " cpu_en R5"}, {7'd0, cpu_clk_en}, {7'd0, e_mode == 2'd0});
    chk({req, " per_en R6"}, {7'd0, per_clk_en}, {7'd0, e_mode != 2'd2});
    chk({req, " osc_en R6"}, {7'd0, osc_en}, {7'd0, e_mode != 2'd2});
    chk({req, " reinit R1"}, {7'd0, reinit_stb}, {7'd0, e_reinit});
    chk("R10 ram_clear", {7'd0, ram_clear}, 8'd0);
  endtask

  task automatic step(logic r, logic w, logic [1:0] d, logic i, string req);
    @(negedge clk);
    rst = r; wr_en = w; wr_data = d; irq = i;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(1, 0, 2'b00, 0, "R1 reset");
    step(0, 0, 2'b00, 0, "R1 after reset");
    step(0, 0, 2'b00, 1, "R9 irq in run");
    step(0, 1, 2'b00, 0, "R9 write zero");
    step(0, 1, 2'b01, 0, "R2 enter idle");
    step(0, 1, 2'b10, 0, "R9 write in idle");
    step(0, 0, 2'b00, 1, "R7 irq wakes");
    step(0, 1, 2'b11, 0, "R4 both bits");
    step(0, 0, 2'b00, 1, "R8 irq in pdn");
    step(0, 1, 2'b01, 0, "R9 write in pdn");
    step(1, 0, 2'b00, 0, "R10 reset from pdn");
    step(0, 1, 2'b10, 0, "R3 enter pdn");
    step(1, 0, 2'b00, 0, "R10 reset again");
    step(0, 1, 2'b01, 0, "R2 idle again");
    step(1, 0, 2'b00, 1, "R10 reset from idle");
    for (int k = 0; k < 2000; k++) begin
      logic r;
      r = ($urandom % 40) == 0;
      step(r, ($urandom % 4) == 0, 2'($urandom), ($urandom % 5) == 0, "R2 R3 R7 R8 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule